// File: doc/BRIEF.md
# Packed Unsigned Halving Add/Subtract Unit

This execution unit takes one 32-bit instruction word and two operand values, and writes back one packed result. Each operand is split into two halfword lanes or four byte lanes. Each lane does an unsigned add or an unsigned subtract, and the lane result is then halved. The halving keeps the carry or borrow that a plain lane-wide operation would lose. Two exchange modes pair each halfword of the first operand with the opposite halfword of the second operand: one lane adds while the other lane subtracts.

The unit drives the two source register indices straight from the instruction, so that a register file can return the operand values in the same cycle. The result, the destination index and a write-enable are registered. A one-cycle valid pulse marks each accepted instruction. Write-enable is gated by a condition code, which is tested against the current N, Z, C and V flags. Opcodes that are not defined never write.

Top module: `phalve_unit`

## Requirements
- R1: `src_a_idx` is `instr[19:16]` and `src_b_idx` is `instr[3:0]`, both combinational. `out_rd` is `instr[15:12]`, registered one cycle after the instruction is accepted.
- R2: When op2 (`instr[7:5]`) is 0, each halfword lane gives (A_h + B_h) >> 1, computed 17 bits wide. Lane 0 occupies bits 15:0 and lane 1 occupies bits 31:16.
- R3: When op2 is 1, the low lane is (A[15:0] − B[31:16]) >> 1 and the high lane is (A[31:16] + B[15:0]) >> 1.
- R4: When op2 is 2, the low lane is (A[15:0] + B[31:16]) >> 1 and the high lane is (A[31:16] − B[15:0]) >> 1.
- R5: When op2 is 3, each halfword lane gives (A_h − B_h) >> 1, computed 17 bits wide, so that a borrow sets bit 15 of the lane.
- R6: When op2 is 4, each of the four byte lanes gives (A_b + B_b) >> 1. When op2 is 7, each byte lane gives (A_b − B_b) >> 1. Both are computed 9 bits wide, with byte 0 in bits 7:0.
- R7: A lane carry or borrow appears as the top bit of that lane. For example, 0xFFFF + 0xFFFF gives 0xFFFF, and 0 − 1 gives 0xFFFF.
- R8: A condition (`instr[31:28]`) of 0xE always writes. A condition of 0xF never writes.
- R9: `flags` is {N,Z,C,V} with N at bit 3. Conditions 0x0 to 0xD follow the standard order and rules: EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT, LE. The unit writes only when the condition holds.
- R10: If op2 is 5 or 6, or the condition fails, `out_we` stays low and `out_result` keeps its previous value.
- R11: `out_valid` is high for exactly the one cycle after each cycle with `in_valid` high. `out_we` is never high without `out_valid`.
- R12: A synchronous active-high `rst` clears `out_valid`, `out_we`, `out_rd` and `out_result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| flags | input | 4 | Current {N,Z,C,V} |
| src_a_val | input | 32 | Value of the first source register |
| src_b_val | input | 32 | Value of the second source register |
| src_a_idx | output | 4 | First source index (combinational) |
| src_b_idx | output | 4 | Second source index (combinational) |
| out_valid | output | 1 | One-cycle pulse per accepted instruction |
| out_we | output | 1 | Write-back enable |
| out_rd | output | 4 | Destination index |
| out_result | output | 32 | Packed halved result |

## Verification
The source indices are combinational, so they are checked a short delay after the instruction is driven, within the same cycle. Every registered output (valid, write-enable, destination and result) is due on the first rising edge after the instruction is presented. The bench drives its inputs on the falling edge and samples the outputs on the following falling edge. It therefore reads exactly one register stage later, and it compares the held result against the last value its model wrote.

// File: rtl/phalve_pkg.sv
package phalve_pkg;

   typedef enum logic [2:0] {
      OP_HADD   = 3'd0,
      OP_HASX   = 3'd1,
      OP_HSAX   = 3'd2,
      OP_HSUB   = 3'd3,
      OP_BADD   = 3'd4,
      OP_RSV5   = 3'd5,
      OP_RSV6   = 3'd6,
      OP_BSUB   = 3'd7
   } pack_op_e;

   localparam logic [3:0] COND_ALWAYS = 4'hE;
   localparam logic [3:0] COND_NEVER  = 4'hF;

endpackage

// File: rtl/phalve_cond.sv
module phalve_cond
   import phalve_pkg::*;
(
   input  logic [3:0] cond,
   input  logic [3:0] flags,
   output logic       pass
);

   logic fn, fz, fc, fv;
   assign {fn, fz, fc, fv} = flags;

   always_comb begin
      unique case (cond)
         4'h0: pass = fz;
         4'h1: pass = !fz;
         4'h2: pass = fc;
         4'h3: pass = !fc;
         4'h4: pass = fn;
         4'h5: pass = !fn;
         4'h6: pass = fv;
         4'h7: pass = !fv;
         4'h8: pass = fc && !fz;
         4'h9: pass = !fc || fz;
         4'hA: pass = (fn == fv);
         4'hB: pass = (fn != fv);
         4'hC: pass = !fz && (fn == fv);
         4'hD: pass = fz || (fn != fv);
         4'hE: pass = 1'b1;
         default: pass = 1'b0;
      endcase
   end

   // R8: the reserved code never passes, the always code always does
   always_comb begin
      a_r8_never_code: assert (!(cond == COND_NEVER) || !pass);
   end

endmodule

// File: rtl/phalve_lanes.sv
module phalve_lanes #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 16
) (
   input  logic [DATA_W-1:0]        opa,
   input  logic [DATA_W-1:0]        opb,
   input  logic [DATA_W/LANE_W-1:0] lane_sub,
   output logic [DATA_W-1:0]        halved
);

   localparam int NLANES = DATA_W / LANE_W;

   if (LANE_W < 2 || (DATA_W % LANE_W) != 0) begin : g_bad_cfg
      $error("phalve_lanes: DATA_W must be a multiple of LANE_W >= 2");
   end

   for (genvar g = 0; g < NLANES; g++) begin : g_lane
      logic [LANE_W-1:0] la, lb;
      logic [LANE_W:0]   wide;
      assign la = opa[g*LANE_W +: LANE_W];
      assign lb = opb[g*LANE_W +: LANE_W];
      assign wide = lane_sub[g] ? ({1'b0, la} - {1'b0, lb})
                                : ({1'b0, la} + {1'b0, lb});
      assign halved[g*LANE_W +: LANE_W] = wide[LANE_W:1];

      // R7: an add whose operands both have the top bit set must carry into the lane top bit
      always_comb begin
         a_r7_carry_top: assert (lane_sub[g] || !(la[LANE_W-1] && lb[LANE_W-1])
                                 || halved[g*LANE_W + LANE_W-1]);
      end
   end

endmodule

// File: rtl/phalve_unit.sv
module phalve_unit
   import phalve_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [31:0]       instr,
   input  logic [3:0]        flags,
   input  logic [DATA_W-1:0] src_a_val,
   input  logic [DATA_W-1:0] src_b_val,
   output logic [IDX_W-1:0]  src_a_idx,
   output logic [IDX_W-1:0]  src_b_idx,
   output logic              out_valid,
   output logic              out_we,
   output logic [IDX_W-1:0]  out_rd,
   output logic [DATA_W-1:0] out_result
);

   localparam int HALF_W = DATA_W / 2;
   localparam int BYTE_W = DATA_W / 4;

   if (DATA_W != 32 || IDX_W != 4) begin : g_bad_cfg
      $error("phalve_unit: field layout fixes DATA_W=32 and IDX_W=4");
   end

   // decode
   logic [3:0]  cond;
   pack_op_e    op2;
   logic [IDX_W-1:0] rd;
   logic        unused_instr_bits;

   assign cond      = instr[31:28];
   assign src_a_idx = instr[19:16];
   assign rd        = instr[15:12];
   assign op2       = pack_op_e'(instr[7:5]);
   assign src_b_idx = instr[3:0];
   assign unused_instr_bits = ^{instr[27:20], instr[11:8], instr[4]};

   // mode select
   logic        op_legal, use_bytes, exchange;
   logic [1:0]  half_sub;
   logic [3:0]  byte_sub;

   always_comb begin
      op_legal  = 1'b1;
      use_bytes = 1'b0;
      exchange  = 1'b0;
      half_sub  = 2'b00;
      byte_sub  = 4'b0000;
      unique case (op2)
         OP_HADD: ;
         OP_HASX: begin exchange = 1'b1; half_sub = 2'b01; end
         OP_HSAX: begin exchange = 1'b1; half_sub = 2'b10; end
         OP_HSUB: half_sub = 2'b11;
         OP_BADD: use_bytes = 1'b1;
         OP_BSUB: begin use_bytes = 1'b1; byte_sub = 4'b1111; end
         default: op_legal = 1'b0;
      endcase
   end

   logic [DATA_W-1:0] half_b, half_res, byte_res, next_res;

   assign half_b = exchange ? {src_b_val[HALF_W-1:0], src_b_val[DATA_W-1:HALF_W]}
                            : src_b_val;

   phalve_lanes #(.DATA_W(DATA_W), .LANE_W(HALF_W)) u_half (
      .opa(src_a_val), .opb(half_b), .lane_sub(half_sub), .halved(half_res)
   );

   phalve_lanes #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_byte (
      .opa(src_a_val), .opb(src_b_val), .lane_sub(byte_sub), .halved(byte_res)
   );

   assign next_res = use_bytes ? byte_res : half_res;

   logic cond_pass, do_write;

   phalve_cond u_cond (.cond(cond), .flags(flags), .pass(cond_pass));

   assign do_write = in_valid && cond_pass && op_legal;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_we     <= 1'b0;
         out_rd     <= '0;
         out_result <= '0;
      end else begin
         out_valid <= in_valid;
         out_we    <= do_write;
         if (in_valid) out_rd <= rd;
         if (do_write) out_result <= next_res;
      end
   end

   // R11: write-enable only together with valid
   a_r11_we_needs_valid: assert property (@(posedge clk) disable iff (rst)
      out_we |-> out_valid);

   // R11: valid follows the accepted instruction by one cycle
   a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R1: registered destination matches the decoded field
   a_r1_rd_field: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_rd == $past(instr[15:12]));

   // R10: undefined opcodes never write
   a_r10_rsv_no_write: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (instr[7:5] == 3'd5 || instr[7:5] == 3'd6)) |=> !out_we);

   // R10: result is held when nothing is written
   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      !out_we |-> $stable(out_result));

endmodule

// File: tb/phalve_unit_tb.sv
module phalve_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [31:0] instr;
   logic [3:0]  flags;
   logic [31:0] src_a_val, src_b_val;
   logic [3:0]  src_a_idx, src_b_idx;
   logic        out_valid, out_we;
   logic [3:0]  out_rd;
   logic [31:0] out_result;

   always #10 clk = ~clk;

   phalve_unit dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .flags(flags),
      .src_a_val(src_a_val), .src_b_val(src_b_val),
      .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
      .out_valid(out_valid), .out_we(out_we), .out_rd(out_rd), .out_result(out_result)
   );

   int checks = 0;
   int fails  = 0;
   logic [31:0] model_res = '0;
   logic [3:0]  model_rd  = '0;
   bit done = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] hv16(input logic [15:0] a, input logic [15:0] b, input bit sub);
      int unsigned w;
      w = sub ? (32'(a) - 32'(b)) : (32'(a) + 32'(b));
      return 16'(w >> 1);
   endfunction

   function automatic logic [7:0] hv8(input logic [7:0] a, input logic [7:0] b, input bit sub);
      int unsigned w;
      w = sub ? (32'(a) - 32'(b)) : (32'(a) + 32'(b));
      return 8'(w >> 1);
   endfunction

   function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
      logic [31:0] r;
      r = '0;
      case (op)
         3'd0: r = {hv16(a[31:16], b[31:16], 0), hv16(a[15:0], b[15:0], 0)};
         3'd1: r = {hv16(a[31:16], b[15:0], 0), hv16(a[15:0], b[31:16], 1)};
         3'd2: r = {hv16(a[31:16], b[15:0], 1), hv16(a[15:0], b[31:16], 0)};
         3'd3: r = {hv16(a[31:16], b[31:16], 1), hv16(a[15:0], b[15:0], 1)};
         3'd4, 3'd7: for (int k = 0; k < 4; k++)
                        r[k*8 +: 8] = hv8(a[k*8 +: 8], b[k*8 +: 8], op == 3'd7);
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic bit cond_ok(input logic [3:0] c, input logic [3:0] f);
      bit n, z, cy, v;
      {n, z, cy, v} = f;
      case (c)
         4'h0: return z;          4'h1: return !z;
         4'h2: return cy;         4'h3: return !cy;
         4'h4: return n;          4'h5: return !n;
         4'h6: return v;          4'h7: return !v;
         4'h8: return cy && !z;   4'h9: return !cy || z;
         4'hA: return n == v;     4'hB: return n != v;
         4'hC: return !z && n == v;
         4'hD: return z || n != v;
         4'hE: return 1;
         default: return 0;
      endcase
   endfunction

   function automatic string op_tag(input logic [2:0] op);
      case (op)
         3'd0: return "R2";  3'd1: return "R3";  3'd2: return "R4";
         3'd3: return "R5";  3'd4, 3'd7: return "R6";
         default: return "R10";
      endcase
   endfunction

   // drive one instruction at negedge, check at next negedge
   task automatic issue(input bit v, input logic [3:0] c, input logic [2:0] op,
                        input logic [3:0] ra, input logic [3:0] rb, input logic [3:0] rd,
                        input logic [31:0] a, input logic [31:0] b, input logic [3:0] f);
      bit wr;
      instr = {c, 8'h67, ra, rd, 4'hF, op, 1'b1, rb};
      in_valid = v; src_a_val = a; src_b_val = b; flags = f;
      #1;
      chk("R1 src_a_idx", 32'(src_a_idx), 32'(ra));
      chk("R1 src_b_idx", 32'(src_b_idx), 32'(rb));
      wr = v && cond_ok(c, f) && !(op == 3'd5 || op == 3'd6);
      if (wr) model_res = model(op, a, b);
      if (v) model_rd = rd;
      @(negedge clk);
      chk("R11 out_valid", 32'(out_valid), 32'(v));
      chk((c >= 4'hE) ? "R8 out_we" : (op == 3'd5 || op == 3'd6) ? "R10 out_we" : "R9 out_we",
          32'(out_we), 32'(wr));
      if (v) chk("R1 out_rd", 32'(out_rd), 32'(model_rd));
      chk(wr ? op_tag(op) : "R10 held", out_result, model_res);
   endtask

   initial begin
      #1500000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      rst = 1; in_valid = 0; instr = '0; flags = '0; src_a_val = '0; src_b_val = '0;
      @(negedge clk); @(negedge clk);
      rst = 0;
      // R12 reset state
      chk("R12 out_valid", 32'(out_valid), 0);
      chk("R12 out_we", 32'(out_we), 0);
      chk("R12 out_rd", 32'(out_rd), 0);
      chk("R12 out_result", out_result, 0);

      // directed corners, R7 carry and borrow to top bit
      issue(1, 4'hE, 3'd0, 1, 2, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'h0);
      chk("R7 carry", out_result, 32'hFFFF_FFFF);
      issue(1, 4'hE, 3'd3, 4, 5, 6, 32'h0000_0000, 32'h0001_0001, 4'h0);
      chk("R7 borrow", out_result, 32'hFFFF_FFFF);
      issue(1, 4'hE, 3'd7, 7, 8, 9, 32'h0000_0000, 32'h0101_0101, 4'h0);
      chk("R7 byte borrow", out_result, 32'hFFFF_FFFF);
      issue(1, 4'hE, 3'd1, 1, 1, 2, 32'h0004_0010, 32'h0002_0006, 4'h0);
      issue(1, 4'hE, 3'd2, 1, 1, 2, 32'h0004_0010, 32'h0002_0006, 4'h0);
      issue(1, 4'hE, 3'd4, 1, 1, 2, 32'h80FF_0102, 32'h80FF_0304, 4'h0);
      // R8 never code; R10 reserved opcodes hold result
      issue(1, 4'hF, 3'd0, 1, 2, 3, 32'h1234_5678, 32'h1111_1111, 4'hF);
      issue(1, 4'hE, 3'd5, 1, 2, 3, 32'h1234_5678, 32'h1111_1111, 4'h0);
      issue(1, 4'hE, 3'd6, 1, 2, 3, 32'h1234_5678, 32'h1111_1111, 4'h0);
      // R9 every condition against every flag pattern
      for (int c = 0; c < 14; c++)
         for (int f = 0; f < 16; f++)
            issue(1, 4'(c), 3'(f & 3), 4'(f), 4'(c), 4'(c + f), $urandom, $urandom, 4'(f));
      // idle cycle: R11 valid low
      issue(0, 4'hE, 3'd0, 0, 0, 0, 32'h1, 32'h1, 4'h0);
      // random mix
      for (int i = 0; i < 600; i++)
         issue(($urandom % 5) != 0, 4'($urandom), 3'($urandom), 4'($urandom), 4'($urandom),
               4'($urandom), $urandom, $urandom, 4'($urandom));
      // R12 reset mid-run
      rst = 1; @(negedge clk); rst = 0; in_valid = 0;
      chk("R12 reset out_result", out_result, 0);
      chk("R12 reset out_valid", 32'(out_valid), 0);
      model_res = '0;
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule